// File: doc/BRIEF.md
# Wait-State Transfer Acknowledge Generator

This block times the acknowledge of one access to one memory region behind a general-purpose chip-select memory controller. A request pulse starts an access. The block then drives chip select and output enable for the access and ends it with a single-cycle transfer acknowledge. The acknowledge comes from one of two sources. One is an internal counter that is loaded from a 4-bit wait-state field. The other is an external acknowledge input that passes through one synchronising flop. A configuration bit picks how the two sources interact. When it is clear, the first source to arrive ends the access. When it is set, only the external acknowledge can end it.

A relaxed-timing bit makes the access longer. It inserts one setup cycle before the strobes are asserted, and it doubles the internal wait-state count. The configuration fields are static inputs, and the block captures them when an access starts. Address decoding, bank choice and the register interface are handled elsewhere.

Top module: `wsack_gen`

## Requirements
- R1: While the synchronous active-high reset is high, and in the cycle after it, `cs_o`, `oe_o` and `ack_o` are low and the block is idle.
- R2: With `cfg_relax_i`=0 and `cfg_ext_only_i`=0 and no external acknowledge, a request sampled at clock edge E gives `cs_o`=`oe_o`=1 from the cycle after E. `ack_o` rises in cycle W+1 after E, where W is `cfg_wait_i` read as an unsigned number (code 0000 = 0 … 1111 = 15).
- R3: `ack_o` is high for exactly one cycle. `cs_o` and `oe_o` are high in that cycle and low in the cycle that follows it.
- R4: With `cfg_ext_only_i`=1, `cfg_wait_i` has no effect. The access ends only through `ext_ack_i`, and `ack_o` is high in the cycle after the edge that samples `ext_ack_i` high.
- R5: With `cfg_ext_only_i`=0, the access ends on whichever acknowledge comes first. An external acknowledge that arrives before the count has run out ends the access early.
- R6: With `cfg_relax_i`=1, the first cycle after the request keeps the strobes low. The strobes then stay high for 2W+1 cycles, so `ack_o` rises in cycle 2W+2 after the request edge.
- R7: `ext_ack_i` sampled while the block is idle is ignored. It produces no `ack_o`, and it does not shorten the next access.
- R8: A request sampled while an access is in progress is ignored. The current access keeps its length, and no new access follows it.
- R9: With `cfg_ext_only_i`=1 and `cfg_relax_i`=1, all strobes are negated in the cycle after the external acknowledge is recognised. An external acknowledge sampled during the setup cycle is recognised in the first strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access start request, accepted only when idle |
| cfg_wait_i | input | 4 | Wait-state count for the internal acknowledge |
| cfg_ext_only_i | input | 1 | 1: only the external acknowledge ends the access |
| cfg_relax_i | input | 1 | 1: setup cycle plus doubled wait count |
| ext_ack_i | input | 1 | External transfer acknowledge |
| cs_o | output | 1 | Chip select strobe |
| oe_o | output | 1 | Output enable strobe |
| ack_o | output | 1 | Single-cycle transfer acknowledge |

## Verification
Every result has a fixed delay from its stimulus. The strobes follow one edge after the request, or two edges when relaxed timing is on. The internal acknowledge comes W+1 cycles after the request, or 2W+2 cycles when relaxed. The external acknowledge appears one cycle after `ext_ack_i` is sampled. The strobes fall one cycle after `ack_o`. The bench drives inputs on falling edges and samples on falling edges, so it counts cycles from the request edge directly. A behavioural model, stepped on each rising edge, predicts all three outputs for every cycle. Directed accesses check the measured acknowledge cycle and the strobe width against the formulas above.

// File: rtl/wsack_pkg.sv
package wsack_pkg;

    localparam int WAIT_W = 4;
    localparam int CNT_W  = WAIT_W + 1;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2
    } phase_e;

    typedef struct packed {
        logic [WAIT_W-1:0] waits;
        logic              ext_only;
        logic              relax;
    } acc_cfg_t;

    // Counter start value: wait count, doubled under relaxed timing.
    function automatic logic [CNT_W-1:0] initial_count(acc_cfg_t c);
        logic [CNT_W-1:0] base;
        base = {{(CNT_W-WAIT_W){1'b0}}, c.waits};
        return c.relax ? (base << 1) : base;
    endfunction

endpackage

// File: rtl/wsack_ext_sync.sv
module wsack_ext_sync (
    input  logic clk,
    input  logic rst,
    input  logic busy_i,
    input  logic ext_ack_i,
    output logic ext_seen_o
);
    // One flop; an acknowledge that arrives while idle is dropped here.
    always_ff @(posedge clk) begin
        if (rst) ext_seen_o <= 1'b0;
        else     ext_seen_o <= ext_ack_i & busy_i;
    end
endmodule

// File: rtl/wsack_wait_counter.sv
module wsack_wait_counter
    import wsack_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                           cnt_q <= '0;
        else if (load_i)                   cnt_q <= load_val_i;
        else if (run_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/wsack_seq.sv
module wsack_seq
    import wsack_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  acc_cfg_t         cfg_i,
    input  logic             ext_seen_i,
    input  logic             cnt_zero_i,
    output logic             busy_o,
    output logic             cnt_load_o,
    output logic [CNT_W-1:0] cnt_val_o,
    output logic             cnt_run_o,
    output logic             strobe_o,
    output logic             done_o
);
    phase_e   phase_q, phase_d;
    acc_cfg_t cfg_q;
    logic     start, int_hit, ext_hit;

    assign start   = (phase_q == PH_IDLE) && req_i;
    assign int_hit = (phase_q == PH_ACTIVE) && cnt_zero_i && !cfg_q.ext_only;
    assign ext_hit = (phase_q == PH_ACTIVE) && ext_seen_i;
    assign done_o  = int_hit || ext_hit;

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:   if (req_i) phase_d = cfg_i.relax ? PH_SETUP : PH_ACTIVE;
            PH_SETUP:  phase_d = PH_ACTIVE;
            PH_ACTIVE: if (done_o) phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cfg_q   <= '0;
        end else begin
            phase_q <= phase_d;
            if (start) cfg_q <= cfg_i;
        end
    end

    assign busy_o     = (phase_q != PH_IDLE);
    assign cnt_load_o = start;
    assign cnt_val_o  = initial_count(cfg_i);
    assign cnt_run_o  = (phase_q == PH_ACTIVE);
    assign strobe_o   = (phase_q == PH_ACTIVE);
endmodule

// File: rtl/wsack_gen.sv
module wsack_gen
    import wsack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [WAIT_W-1:0] cfg_wait_i,
    input  logic              cfg_ext_only_i,
    input  logic              cfg_relax_i,
    input  logic              ext_ack_i,
    output logic              cs_o,
    output logic              oe_o,
    output logic              ack_o
);
    acc_cfg_t         cfg;
    logic             busy, ext_seen, cnt_zero, cnt_load, cnt_run, strobe, done;
    logic [CNT_W-1:0] cnt_val;

    assign cfg = '{waits: cfg_wait_i, ext_only: cfg_ext_only_i, relax: cfg_relax_i};

    wsack_ext_sync u_sync (
        .clk(clk), .rst(rst), .busy_i(busy),
        .ext_ack_i(ext_ack_i), .ext_seen_o(ext_seen)
    );

    wsack_wait_counter u_cnt (
        .clk(clk), .rst(rst), .load_i(cnt_load),
        .load_val_i(cnt_val), .run_i(cnt_run), .zero_o(cnt_zero)
    );

    wsack_seq u_seq (
        .clk(clk), .rst(rst), .req_i(req_i), .cfg_i(cfg),
        .ext_seen_i(ext_seen), .cnt_zero_i(cnt_zero), .busy_o(busy),
        .cnt_load_o(cnt_load), .cnt_val_o(cnt_val), .cnt_run_o(cnt_run),
        .strobe_o(strobe), .done_o(done)
    );

    assign cs_o  = strobe;
    assign oe_o  = strobe;
    assign ack_o = done;
endmodule

// File: rtl/wsack_gen_chk.sv
module wsack_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_i,
    input logic [3:0] cfg_wait_i,
    input logic       cfg_ext_only_i,
    input logic       cfg_relax_i,
    input logic       ext_ack_i,
    input logic       cs_o,
    input logic       oe_o,
    input logic       ack_o
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!cs_o && !oe_o && !ack_o));

    p_ack_inside_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> (cs_o && oe_o));

    p_ack_single_r3: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);

    p_strobe_drop_r3: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> (!cs_o && !oe_o));

    p_strobe_pair_r2: assert property (@(posedge clk) disable iff (rst)
        cs_o == oe_o);

    p_normal_start_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(cs_o) && !cfg_relax_i) |-> $past(req_i));

    p_relax_setup_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(cs_o) && cfg_relax_i) |-> ($past(req_i, 2) && !$past(cs_o)));

    p_ext_only_source_r4: assert property (@(posedge clk) disable iff (rst)
        (ack_o && cfg_ext_only_i) |-> $past(ext_ack_i));
endmodule

bind wsack_gen wsack_gen_chk u_chk (
    .clk(clk), .rst(rst), .req_i(req_i), .cfg_wait_i(cfg_wait_i),
    .cfg_ext_only_i(cfg_ext_only_i), .cfg_relax_i(cfg_relax_i),
    .ext_ack_i(ext_ack_i), .cs_o(cs_o), .oe_o(oe_o), .ack_o(ack_o)
);

// File: tb/wsack_gen_bench.sv
module wsack_gen_bench;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic [3:0] wcfg = 4'd0;
    logic       xonly = 1'b0;
    logic       relax = 1'b0;
    logic       xack = 1'b0;
    logic       cs, oe, ack;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done_flag = 1'b0;

    // behavioural reference state
    int m_phase = 0;   // 0 idle, 1 setup, 2 strobes on
    int m_left  = 0;
    bit m_ext   = 1'b0;

    wsack_gen u_wsack_gen (
        .clk(clk), .rst(rst), .req_i(req), .cfg_wait_i(wcfg),
        .cfg_ext_only_i(xonly), .cfg_relax_i(relax), .ext_ack_i(xack),
        .cs_o(cs), .oe_o(oe), .ack_o(ack)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic bit model_ack();
        return (m_phase == 2) && ((!xonly && m_left == 0) || m_ext);
    endfunction

    always @(posedge clk) begin
        bit fin;
        fin = model_ack();
        if (rst) begin
            m_phase <= 0; m_left <= 0; m_ext <= 1'b0;
        end else begin
            m_ext <= xack && (m_phase != 0);
            if (m_phase == 0) begin
                if (req) begin
                    m_phase <= relax ? 1 : 2;
                    m_left  <= relax ? 2 * int'(wcfg) : int'(wcfg);
                end
            end else if (m_phase == 1) begin
                m_phase <= 2;
            end else if (fin) begin
                m_phase <= 0;
            end else if (m_left > 0) begin
                m_left <= m_left - 1;
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the reference (covers R2 R3 R4 R5 R6 R7 R8 R9)
    always @(negedge clk) begin
        if (!rst) begin
            int exp_s;
            exp_s = (m_phase == 2) ? 1 : 0;
            check("model cs R2", int'(cs), exp_s);
            check("model oe R2", int'(oe), exp_s);
            check("model ack R3", int'(ack), int'(model_ack()));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done_flag) begin
            done_flag = 1'b1;
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // One access; ext_at = sample index after which ext_ack_i is pulsed (0: never).
    task automatic access(string tag, int w, bit xo, bit rl, int ext_at, int exp_n, bit req_again);
        int n = 0;
        int on = 0;
        int got = -1;
        @(negedge clk);
        wcfg = 4'(w); xonly = xo; relax = rl; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        while (got < 0 && n < 80) begin
            n++;
            if (cs) on++;
            if (ack) got = n;
            xack = (n == ext_at);
            if (req_again) req = (n == 2);
            @(negedge clk);
            xack = 1'b0; req = 1'b0;
        end
        check({tag, " ack cycle"}, got, exp_n);
        check({tag, " strobe width"}, on, exp_n - (rl ? 1 : 0));
        check("R3 strobe low after ack", int'(cs || oe), 0);
        repeat (3) begin
            @(negedge clk);
            check("R8 no stray access", int'(cs || ack), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 cs in reset", int'(cs), 0);
        check("R1 ack in reset", int'(ack), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", int'(cs || oe || ack), 0);

        access("R2 w0",  0,  0, 0, 0, 1,  0);
        access("R2 w1",  1,  0, 0, 0, 2,  0);
        access("R2 w5",  5,  0, 0, 0, 6,  0);
        access("R2 w15", 15, 0, 0, 0, 16, 0);
        access("R4 wait ignored", 2,  1, 0, 6, 7, 0);
        access("R4 early ext",    15, 1, 0, 1, 2, 0);
        access("R5 ext first",    10, 0, 0, 3, 4, 0);
        access("R5 count first",  2,  0, 0, 8, 3, 0);
        access("R6 relax w0",     0,  0, 1, 0, 2, 0);
        access("R6 relax w3",     3,  0, 1, 0, 8, 0);
        access("R9 relax ext",    0,  1, 1, 4, 5, 0);
        access("R9 ext in setup", 9,  1, 1, 1, 2, 0);
        access("R8 req while busy", 4, 0, 0, 0, 5, 1);

        // R7: ext acknowledge while idle
        @(negedge clk);
        xack = 1'b1;
        @(negedge clk);
        xack = 1'b0;
        repeat (3) begin
            check("R7 no ack when idle", int'(ack), 0);
            @(negedge clk);
        end
        access("R7 next access full", 3, 0, 0, 0, 4, 0);

        // R1: reset in the middle of an access
        @(negedge clk);
        wcfg = 4'd9; xonly = 1'b0; relax = 1'b0; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset aborts", int'(cs || oe || ack), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after abort", int'(cs || ack), 0);

        done_flag = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule